// File: doc/BRIEF.md
# Chip-Enable Framed Serial Register Loader

This block receives control settings over a three-line synchronous serial link made of an enable line, a serial clock and a serial data line. The three lines are asynchronous to the system clock and are resynchronised and oversampled. Each frame starts with an address byte, shifted in while the enable line is low. The enable line then goes high and the payload is shifted in. When the enable line falls, the frame is closed. The address picks one of two register banks. A voice bank holds the line select, key enable, two microphone volumes and four test bits. An echo bank holds the delay select, echo volume and feedback volume.

The bank registers drive the outputs, and they change only once a complete, well-formed frame has closed. A frame that is cut short, too long, or sent to an unknown address leaves every output as it was. Bits are sampled on rising serial clock edges, so the link works whether the serial clock idles high or idles low. While the enable line stays low, the data phase can never start, so the same clock and data wires can carry another bus without any effect on this block.

Top module: `ce_serial_loader`

## Requirements
- R1: While and after synchronous reset, with no frame received, every output is zero.
- R2: The address is formed from the rising serial clock edges counted since the last enable fall (or since reset), taken while enable is low. The first bit received is address bit 0. The voice bank answers to address 8'hC4 and the echo bank to 8'hC5. A bit-reversed address is not accepted.
- R3: After a valid voice frame, the payload bits map as follows, where payload bit i is the i-th data bit received. Bits [2:0] go to line_sel, bit 3 to key_en, bits [6:4] to mic1_vol, bits [9:7] to mic2_vol and bits [13:10] to test_bits. Bits 14 and 15 are dropped.
- R4: After a valid echo frame, bits [2:0] go to delay_sel, bits [5:3] to echo_vol and bits [8:6] to fb_vol. Bits [15:9] are dropped.
- R5: Outputs never change during a frame. The new values appear on the fourth system clock edge after the first edge that sees enable low.
- R6: A frame with eight address bits and an address other than the two bank addresses changes no output.
- R7: A frame whose data phase holds fewer or more than 16 rising clock edges changes no output.
- R8: A frame with fewer or more than 8 address clock edges changes no output.
- R9: Frames sent with the serial clock idling high load exactly as frames sent with it idling low.
- R10: Serial clock and data activity while enable stays low changes no output.
- R11: Loading one bank leaves the other bank's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_ce | input | 1 | Frame enable: low for address, high for payload, falling edge closes the frame |
| ser_clk | input | 1 | Serial clock; bits are sampled on its rising edge |
| ser_dat | input | 1 | Serial data |
| line_sel | output | 3 | Voice bank: line output select code |
| key_en | output | 1 | Voice bank: key control enable |
| mic1_vol | output | 3 | Voice bank: microphone 1 volume code |
| mic2_vol | output | 3 | Voice bank: microphone 2 volume code |
| test_bits | output | 4 | Voice bank: test field |
| delay_sel | output | 3 | Echo bank: delay select code |
| echo_vol | output | 3 | Echo bank: echo volume code |
| fb_vol | output | 3 | Echo bank: feedback volume code |

## Verification
The bench uses the default parameters: an 8-bit address, a 16-bit payload, two synchroniser stages and bank addresses C4 and C5. With these values, the bit reversal of each bank address is an invalid address, so an address sent in the wrong bit order is caught. Nine address bits whose last eight equal a bank address are also possible, which shows that the bit count matters and not only the shifted content. With two stages the update latency is a fixed four edges, so the reference model can predict the exact cycle in which the outputs change. It checks every cycle that nothing moves earlier.

// File: rtl/sload_pkg.sv
package sload_pkg;

  // Voice bank fields, listed from MSB down; line_sel lands on the low bits.
  typedef struct packed {
    logic [3:0] test;
    logic [2:0] mic2;
    logic [2:0] mic1;
    logic       key;
    logic [2:0] line;
  } voice_cfg_t;

  // Echo bank fields, listed from MSB down; delay lands on the low bits.
  typedef struct packed {
    logic [2:0] fb;
    logic [2:0] echo;
    logic [2:0] delay;
  } echo_cfg_t;

endpackage

// File: rtl/sload_sync.sv
module sload_sync #(
  parameter int LINES  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] lvl
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], din[g]};
    end
    assign lvl[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/sload_frame.sv
module sload_frame #(
  parameter int              ADDR_W    = 8,
  parameter int              DATA_BITS = 16,
  parameter int              OUT_W     = 14,
  parameter logic [ADDR_W-1:0] ADDR_A  = 8'hC4,
  parameter logic [ADDR_W-1:0] ADDR_B  = 8'hC5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce_lvl,
  input  logic             sck_lvl,
  input  logic             sdi_lvl,
  output logic             load_a,
  output logic             load_b,
  output logic [OUT_W-1:0] word
);

  localparam int ACNT_W = $clog2(ADDR_W + 2);
  localparam int DCNT_W = $clog2(DATA_BITS + 2);
  localparam logic [ACNT_W-1:0] ACNT_FULL = ACNT_W'(ADDR_W);
  localparam logic [ACNT_W-1:0] ACNT_SAT  = ACNT_W'(ADDR_W + 1);
  localparam logic [DCNT_W-1:0] DCNT_FULL = DCNT_W'(DATA_BITS);
  localparam logic [DCNT_W-1:0] DCNT_SAT  = DCNT_W'(DATA_BITS + 1);

  logic                 ce_prev, sck_prev;
  logic                 ce_rise, ce_fall, sck_rise;
  logic [ADDR_W-1:0]    addr_sr;
  logic [ACNT_W-1:0]    addr_cnt;
  logic [DATA_BITS-1:0] data_sr;
  logic [DCNT_W-1:0]    data_cnt;
  logic                 hit_a, hit_b;
  logic                 len_ok;

  assign ce_rise  = ce_lvl & ~ce_prev;
  assign ce_fall  = ~ce_lvl & ce_prev;
  assign sck_rise = sck_lvl & ~sck_prev;
  assign len_ok   = (data_cnt == DCNT_FULL);
  assign word     = data_sr[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_prev  <= 1'b0;
      sck_prev <= 1'b0;
      addr_sr  <= '0;
      addr_cnt <= '0;
      data_sr  <= '0;
      data_cnt <= '0;
      hit_a    <= 1'b0;
      hit_b    <= 1'b0;
      load_a   <= 1'b0;
      load_b   <= 1'b0;
    end else begin
      ce_prev  <= ce_lvl;
      sck_prev <= sck_lvl;
      load_a   <= 1'b0;
      load_b   <= 1'b0;
      if (ce_fall) begin
        load_a   <= hit_a & len_ok;
        load_b   <= hit_b & len_ok;
        addr_cnt <= '0;
        data_cnt <= '0;
        hit_a    <= 1'b0;
        hit_b    <= 1'b0;
      end else if (ce_rise) begin
        hit_a    <= (addr_cnt == ACNT_FULL) && (addr_sr == ADDR_A);
        hit_b    <= (addr_cnt == ACNT_FULL) && (addr_sr == ADDR_B);
        data_cnt <= '0;
      end else if (sck_rise) begin
        if (ce_lvl) begin
          data_sr <= {sdi_lvl, data_sr[DATA_BITS-1:1]};
          if (data_cnt != DCNT_SAT) data_cnt <= data_cnt + 1'b1;
        end else begin
          addr_sr <= {sdi_lvl, addr_sr[ADDR_W-1:1]};
          if (addr_cnt != ACNT_SAT) addr_cnt <= addr_cnt + 1'b1;
        end
      end
    end
  end

  AST_LOAD_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({load_a, load_b})); // R11
  AST_LOAD_NEEDS_FALL: assert property (@(posedge clk) disable iff (rst)
    (load_a || load_b) |-> $past(ce_fall)); // R5
  AST_LOAD_CE_LOW: assert property (@(posedge clk) disable iff (rst)
    (load_a || load_b) |-> !ce_lvl); // R10

endmodule

// File: rtl/sload_bank.sv
module sload_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q)); // R5

endmodule

// File: rtl/ce_serial_loader.sv
module ce_serial_loader #(
  parameter int                ADDR_W      = 8,
  parameter int                DATA_BITS   = 16,
  parameter logic [ADDR_W-1:0] ADDR_VOICE  = 8'hC4,
  parameter logic [ADDR_W-1:0] ADDR_ECHO   = 8'hC5,
  parameter int                SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ser_ce,
  input  logic       ser_clk,
  input  logic       ser_dat,
  output logic [2:0] line_sel,
  output logic       key_en,
  output logic [2:0] mic1_vol,
  output logic [2:0] mic2_vol,
  output logic [3:0] test_bits,
  output logic [2:0] delay_sel,
  output logic [2:0] echo_vol,
  output logic [2:0] fb_vol
);

  import sload_pkg::*;

  localparam int VW = $bits(voice_cfg_t);
  localparam int EW = $bits(echo_cfg_t);

  logic [2:0]    lvl;
  logic          load_a, load_b;
  logic [VW-1:0] word;
  logic [VW-1:0] a_q;
  logic [EW-1:0] b_q;
  voice_cfg_t    vcfg;
  echo_cfg_t     ecfg;

  sload_sync #(.LINES(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({ser_dat, ser_clk, ser_ce}),
    .lvl (lvl)
  );

  sload_frame #(
    .ADDR_W    (ADDR_W),
    .DATA_BITS (DATA_BITS),
    .OUT_W     (VW),
    .ADDR_A    (ADDR_VOICE),
    .ADDR_B    (ADDR_ECHO)
  ) u_frame (
    .clk     (clk),
    .rst     (rst),
    .ce_lvl  (lvl[0]),
    .sck_lvl (lvl[1]),
    .sdi_lvl (lvl[2]),
    .load_a  (load_a),
    .load_b  (load_b),
    .word    (word)
  );

  sload_bank #(.W(VW)) u_voice (
    .clk (clk), .rst (rst), .load (load_a), .d (word), .q (a_q)
  );

  sload_bank #(.W(EW)) u_echo (
    .clk (clk), .rst (rst), .load (load_b), .d (word[EW-1:0]), .q (b_q)
  );

  assign vcfg      = voice_cfg_t'(a_q);
  assign ecfg      = echo_cfg_t'(b_q);
  assign line_sel  = vcfg.line;
  assign key_en    = vcfg.key;
  assign mic1_vol  = vcfg.mic1;
  assign mic2_vol  = vcfg.mic2;
  assign test_bits = vcfg.test;
  assign delay_sel = ecfg.delay;
  assign echo_vol  = ecfg.echo;
  assign fb_vol    = ecfg.fb;

  AST_OUT_NEEDS_LOAD: assert property (@(posedge clk) disable iff (rst)
    !$stable({a_q, b_q}) |-> $past(load_a || load_b)); // R5
  AST_VOICE_ONLY_ON_A: assert property (@(posedge clk) disable iff (rst)
    !$stable(a_q) |-> $past(load_a)); // R11

endmodule

// File: tb/tb_ce_serial_loader.sv
module tb_ce_serial_loader;

  localparam int HALF = 4;
  localparam logic [7:0] A_ADDR = 8'hC4;
  localparam logic [7:0] B_ADDR = 8'hC5;

  logic clk = 1'b0, rst = 1'b1, ce = 1'b0, sck = 1'b0, sdi = 1'b0;
  logic [2:0] line_sel, mic1_vol, mic2_vol, delay_sel, echo_vol, fb_vol;
  logic       key_en;
  logic [3:0] test_bits;

  always #5 clk = ~clk;

  ce_serial_loader dut (
    .clk (clk), .rst (rst), .ser_ce (ce), .ser_clk (sck), .ser_dat (sdi),
    .line_sel (line_sel), .key_en (key_en), .mic1_vol (mic1_vol),
    .mic2_vol (mic2_vol), .test_bits (test_bits), .delay_sel (delay_sel),
    .echo_vol (echo_vol), .fb_vol (fb_vol)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    compared = 0, mismatched = 0;
  string cur_req = "R1";
  logic [13:0] exp_a = '0;
  logic [8:0]  exp_b = '0;
  int          due_q[$];
  bit          sel_q[$];
  logic [15:0] val_q[$];
  int  abits = 0, dbits = 0;
  bit  idle_hi = 1'b0;
  bit  finished = 1'b0;

  // Reference model: apply scheduled updates, then compare every cycle.
  always @(negedge clk) begin
    logic [13:0] act_a;
    logic [8:0]  act_b;
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      if (sel_q[0]) exp_b = val_q[0][8:0];
      else          exp_a = val_q[0][13:0];
      void'(due_q.pop_front());
      void'(sel_q.pop_front());
      void'(val_q.pop_front());
    end
    if (!finished && cyc >= 1) begin
      act_a = {test_bits, mic2_vol, mic1_vol, key_en, line_sel};
      act_b = {fb_vol, echo_vol, delay_sel};
      compared++;
      if (act_a !== exp_a || act_b !== exp_b) begin
        mismatched++;
        $display("FAIL %s cycle %0d: voice actual %h expected %h, echo actual %h expected %h",
                 cur_req, cyc, act_a, exp_a, act_b, exp_b);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic put_bit(input logic b);
    sdi = b;
    tick(HALF);
    if (idle_hi) begin
      sck = 1'b0;
      tick(HALF);
      sck = 1'b1;
    end else begin
      sck = 1'b1;
    end
    if (ce) dbits++;
    else    abits++;
    tick(HALF);
    if (!idle_hi) sck = 1'b0;
  endtask

  task automatic set_idle(input bit v);
    if (v && !sck && !ce) abits++;
    sck = v;
    idle_hi = v;
    tick(HALF);
  endtask

  task automatic send_frame(input int na, input logic [15:0] addr,
                            input int nd, input logic [31:0] data);
    for (int i = 0; i < na; i++) put_bit(addr[i]);
    tick(HALF);
    ce = 1'b1;
    dbits = 0;
    tick(HALF);
    for (int i = 0; i < nd; i++) put_bit(data[i]);
    tick(HALF);
    ce = 1'b0;
    if (abits == 8 && dbits == 16 &&
        (addr[7:0] == A_ADDR || addr[7:0] == B_ADDR) && na == 8) begin
      due_q.push_back(cyc + 4);
      sel_q.push_back(addr[7:0] == B_ADDR);
      val_q.push_back(data[15:0]);
    end
    abits = 0;
    tick(HALF * 2);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog (all requirements): actual hung, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(10);                                   // R1: zeros after reset

    cur_req = "R3";
    send_frame(8, 16'(A_ADDR), 16, 32'h2B6D);
    send_frame(8, 16'(A_ADDR), 16, 32'hD492);

    cur_req = "R4";                              // also R11: voice bank held
    send_frame(8, 16'(B_ADDR), 16, 32'hFE35);
    send_frame(8, 16'(B_ADDR), 16, 32'h01CA);

    cur_req = "R2";
    send_frame(8, 16'h23, 16, 32'h1111);        // C4 bit-reversed
    send_frame(8, 16'hA3, 16, 32'h2222);        // C5 bit-reversed

    cur_req = "R6";
    send_frame(8, 16'hC6, 16, 32'h3333);
    send_frame(8, 16'h00, 16, 32'h7FFF);

    cur_req = "R7";
    send_frame(8, 16'(A_ADDR), 15, 32'h0F0F);
    send_frame(8, 16'(B_ADDR), 17, 32'h1F0F0);

    cur_req = "R8";
    send_frame(7, 16'h44, 16, 32'h5A5A);
    send_frame(9, 16'h189, 16, 32'hA5A5);

    cur_req = "R10";
    for (int i = 0; i < 20; i++) put_bit(logic'(i % 3 == 0));
    tick(HALF * 4);
    send_frame(0, 16'h0, 0, 32'h0);             // empty frame resets counts
    send_frame(8, 16'(A_ADDR), 16, 32'h3C81);

    cur_req = "R9";
    set_idle(1'b1);
    send_frame(0, 16'h0, 0, 32'h0);
    send_frame(8, 16'(A_ADDR), 16, 32'h1357);
    send_frame(8, 16'(B_ADDR), 16, 32'hFFFF);
    send_frame(8, 16'hC6, 16, 32'h0000);
    set_idle(1'b0);

    cur_req = "R5";
    send_frame(8, 16'(A_ADDR), 16, 32'h0000);
    send_frame(8, 16'(B_ADDR), 16, 32'h0155);

    cur_req = "R11";
    send_frame(8, 16'(A_ADDR), 16, 32'h3FFF);

    tick(20);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule